// File: doc/BRIEF.md
# Multiplexed Control Port Reset Configuration Controller

This block owns an eight-pin port whose pins can either serve the external bus controller or act as plain software I/O. From reset onward it decides, pin by pin, whether the pad is left on a weak pull-up, driven strongly with a bus control signal, handed to the bus controller as an input, or driven from the port data and output-enable registers. Each pin leaves its weak-high reset state on its own trigger. Some pins are released by the first write to the port mode register. Others are released by the end of the configuration fetch, or straight after reset when the external-access strap is set.

The strap and pin 4 are captured while reset is held. Their values at the last reset clock are kept until the next reset. A low level on pin 4 at that time raises a special-mode request. The configuration fields that matter to the port (bus width and the wait-state field) are latched on the first fetch-done strobe only. The address-strobe select is taken live. The block also flags the one setting known to hang external accesses: the ready pin has been requested by configuration, but software has put that pin in I/O mode.

Top module: `port_pin_cfg`

## Requirements
- R1: While `rst_n` is low, all pins have `pull_en`=1, `drv_en`=0 and `pin_out`=1. After reset, a pin that has not yet been released keeps that same weak-high state.
- R2: With the strap high at reset (external access), pins 0 and 3 are strongly driven right after reset. Pin 0 carries `bus_ale` when `cfg_alsel`=0 and `bus_adv` when it is 1. Pin 3 carries `bus_rd`.
- R3: With the strap low at reset (internal access), pins 0 and 3 stay weak-high until the first mode-register write.
- R4: `strap_ext` is captured on every clock while `rst_n` is low. The value from the last reset clock is used, and later changes on `strap_ext` have no effect.
- R5: After the fetch completes, pin 5 is strongly driven with `bus_bhe` if the latched bus-width bit is 1. If that bit is 0, pin 5 stays weak-high until a mode write.
- R6: After the fetch completes, pin 6 becomes the ready input if the wait-state field is all ones. In that case `drv_en[6]`=0 and `ready_in` follows `pin_in[6]`. For any other value, pin 6 becomes port I/O (`drv_en[6]`=`port_oe[6]`, `pin_out[6]`=`port_dout[6]`). `ready_in` is 1 whenever pin 6 is not the ready input.
- R7: Pins 1, 2, 4 and 7 stay weak-high until the first mode write. The fetch-done strobe does not release them.
- R8: `test_req` is 1 when `pin_in[4]` was low on the last reset clock. It holds that value until the next reset.
- R9: After the first mode write, no pin is weak. Mode bit n=1 selects the system function of pin n. Pins 0,1,2,3,5 then drive ALE/ADV, `bus_inst`, `bus_wr`, `bus_rd` and `bus_bhe` strongly. Pins 6 and 7 become the inputs `ready_in` and `width_in` and are not driven. Pin 4 has no system function and stays I/O. Mode bit n=0 makes pin n I/O, with `drv_en`=`port_oe[n]` and `pin_out`=`port_dout[n]`.
- R10: `cfg_conflict` is 1 exactly when the latched wait-state field is all ones, the mode register has been written, and mode bit 6 is 0.
- R11: Fetch and release state is sticky until reset. A second `cfg_done` pulse, even with different config fields, changes no pin.
- R12: `port_din` always equals `pin_in`. `width_in` follows `pin_in[7]` when pin 7 is in system mode and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_ext | input | 1 | Access strap, 1 = external access |
| cfg_done | input | 1 | Configuration fetch complete strobe |
| cfg_alsel | input | 1 | 0 = address latch strobe, 1 = address-valid strobe on pin 0 |
| cfg_wide | input | 1 | Bus-width configuration bit |
| cfg_wait | input | WAIT_W | Wait-state configuration field |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| port_dout | input | 8 | Port data register |
| port_oe | input | 8 | Port output enables |
| bus_ale | input | 1 | Address latch strobe from the bus controller |
| bus_adv | input | 1 | Address-valid strobe from the bus controller |
| bus_inst | input | 1 | Instruction fetch indicator |
| bus_wr | input | 1 | Write / low-byte write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_bhe | input | 1 | High-byte enable / high-byte write |
| pin_in | input | 8 | Pad input levels |
| pull_en | output | 8 | Weak pull-up enable per pin |
| drv_en | output | 8 | Strong drive enable per pin |
| pin_out | output | 8 | Output value per pin |
| port_din | output | 8 | Pad levels routed to the port input register |
| ready_in | output | 1 | Ready to the bus controller |
| width_in | output | 1 | Bus width input to the bus controller |
| test_req | output | 1 | Special-mode entry request |
| cfg_conflict | output | 1 | Ready configured but pin set to I/O |

## Verification
The bench builds the block with its default `WAIT_W` of 3. That keeps the all-ones wait-state value one of only eight codes, so it can be exercised next to near-miss codes such as 101. Both strap polarities are run through reset, along with a second fetch strobe that carries opposite config values. Mode-register patterns are applied so that system, input-function and I/O pins mix within one write.

// File: rtl/port_pin_cfg.sv
module port_pin_cfg #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_ext,
  input  logic              cfg_done,
  input  logic              cfg_alsel,
  input  logic              cfg_wide,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              mode_we,
  input  logic [7:0]        mode_wdata,
  input  logic [7:0]        port_dout,
  input  logic [7:0]        port_oe,
  input  logic              bus_ale,
  input  logic              bus_adv,
  input  logic              bus_inst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_bhe,
  input  logic [7:0]        pin_in,
  output logic [7:0]        pull_en,
  output logic [7:0]        drv_en,
  output logic [7:0]        pin_out,
  output logic [7:0]        port_din,
  output logic              ready_in,
  output logic              width_in,
  output logic              test_req,
  output logic              cfg_conflict
);
  localparam logic [7:0] OUT_FN  = 8'b0010_1111;
  localparam logic [7:0] NO_FN   = 8'b0001_0000;

  logic       strap_q, tst_q, fetched, sw_rel, wide_q, rdy_q;
  logic [7:0] mode_q, hw_sys, hw_io, rel, sys, fn, sys_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= strap_ext;
      tst_q   <= ~pin_in[4];
      fetched <= 1'b0;
      sw_rel  <= 1'b0;
      wide_q  <= 1'b0;
      rdy_q   <= 1'b0;
      mode_q  <= '0;
    end else begin
      if (cfg_done && !fetched) begin
        fetched <= 1'b1;
        wide_q  <= cfg_wide;
        rdy_q   <= &cfg_wait;
      end
      if (mode_we) begin
        sw_rel <= 1'b1;
        mode_q <= mode_wdata;
      end
    end
  end

  assign hw_sys  = {1'b0, fetched & rdy_q, fetched & wide_q, 1'b0, strap_q, 2'b00, strap_q};
  assign hw_io   = {1'b0, fetched & ~rdy_q, 6'b0};
  assign rel     = !rst_n ? 8'h00 : (sw_rel ? 8'hFF : (hw_sys | hw_io));
  assign sys     = !rst_n ? 8'h00 : (sw_rel ? (mode_q & ~NO_FN) : hw_sys);
  assign fn      = {2'b00, bus_bhe, 1'b0, bus_rd, bus_wr, bus_inst,
                    cfg_alsel ? bus_adv : bus_ale};
  assign sys_out = sys & OUT_FN;

  assign pull_en      = ~rel;
  assign drv_en       = rel & (sys_out | (~sys & port_oe));
  assign pin_out      = ~rel | (sys_out & fn) | (~sys_out & port_dout);
  assign port_din     = pin_in;
  assign ready_in     = sys[6] ? pin_in[6] : 1'b1;
  assign width_in     = sys[7] ? pin_in[7] : 1'b0;
  assign test_req     = tst_q;
  assign cfg_conflict = rdy_q & sw_rel & ~mode_q[6];

  a_r1_weak_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rel && !fetched && !strap_q) |-> (pull_en == 8'hFF && drv_en == 8'h00));
  a_r4_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($stable(strap_q) && $stable(test_req)));
  a_r5_bhe_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (fetched && wide_q && !sw_rel) |-> (drv_en[5] && pin_out[5] == bus_bhe));
  a_r7_late_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rel |-> (pull_en[1] && pull_en[2] && pull_en[4] && pull_en[7]));
  a_r9_all_released: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rel |-> (pull_en == 8'h00));
  a_r10_conflict_io: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_conflict |-> (ready_in && !pull_en[6]));
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fetched |=> (fetched && $stable(wide_q) && $stable(rdy_q)));
endmodule

// File: tb/sim_port_pin_cfg.sv
module sim_port_pin_cfg;
  logic       clk = 1'b0;
  logic       rst_n, strap_ext, cfg_done, cfg_alsel, cfg_wide, mode_we;
  logic [2:0] cfg_wait;
  logic [7:0] mode_wdata, port_dout, port_oe, pin_in;
  logic       bus_ale, bus_adv, bus_inst, bus_wr, bus_rd, bus_bhe;
  logic [7:0] pull_en, drv_en, pin_out, port_din;
  logic       ready_in, width_in, test_req, cfg_conflict;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  port_pin_cfg #(.WAIT_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_ext(strap_ext), .cfg_done(cfg_done),
    .cfg_alsel(cfg_alsel), .cfg_wide(cfg_wide), .cfg_wait(cfg_wait),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .port_dout(port_dout),
    .port_oe(port_oe), .bus_ale(bus_ale), .bus_adv(bus_adv), .bus_inst(bus_inst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_bhe(bus_bhe), .pin_in(pin_in),
    .pull_en(pull_en), .drv_en(drv_en), .pin_out(pin_out), .port_din(port_din),
    .ready_in(ready_in), .width_in(width_in), .test_req(test_req),
    .cfg_conflict(cfg_conflict));

  // {mode, oe, dout, exp_drv, exp_out}; bus: ale=1 adv=0 inst=0 wr=1 rd=0 bhe=1, alsel=0
  localparam logic [39:0] VEC [5] = '{
    {8'hFF, 8'h00, 8'h00, 8'h2F, 8'h25},
    {8'h00, 8'hFF, 8'hA5, 8'hFF, 8'hA5},
    {8'h0F, 8'hF0, 8'h3C, 8'hFF, 8'h35},
    {8'hC0, 8'h0F, 8'hFF, 8'h0F, 8'hFF},
    {8'h30, 8'h00, 8'h00, 8'h20, 8'h20}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset(input logic strap, input logic p4);
    @(negedge clk);
    rst_n = 1'b0; strap_ext = strap; pin_in[4] = p4;
    mode_we = 1'b0; cfg_done = 1'b0;
    repeat (3) step();
  endtask

  task automatic fetch(input logic wide, input logic [2:0] w);
    cfg_wide = wide; cfg_wait = w; cfg_done = 1'b1;
    step();
    cfg_done = 1'b0;
  endtask

  task automatic mode_write(input logic [7:0] m);
    mode_wdata = m; mode_we = 1'b1;
    step();
    mode_we = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_alsel = 1'b0; cfg_wide = 1'b0; cfg_wait = 3'b000;
    mode_wdata = 8'h00; port_dout = 8'h00; port_oe = 8'h00; pin_in = 8'hFF;
    bus_ale = 1'b1; bus_adv = 1'b0; bus_inst = 1'b0; bus_wr = 1'b1;
    bus_rd = 1'b0; bus_bhe = 1'b1; strap_ext = 1'b1; mode_we = 1'b0; cfg_done = 1'b0;

    // external strap
    do_reset(1'b1, 1'b1);
    check("R1 pull in reset", pull_en, 8'hFF);
    check("R1 drv in reset", drv_en, 8'h00);
    check("R1 out in reset", pin_out, 8'hFF);
    rst_n = 1'b1;
    step();
    check("R2 drv ext", drv_en, 8'h09);
    check("R1 pull ext", pull_en, 8'hF6);
    check("R2 pin0 ale", {7'b0, pin_out[0]}, 8'h01);
    check("R2 pin3 rd", {7'b0, pin_out[3]}, 8'h00);
    check("R8 no test req", {7'b0, test_req}, 8'h00);
    cfg_alsel = 1'b1;
    #1 check("R2 pin0 adv", {7'b0, pin_out[0]}, 8'h00);
    cfg_alsel = 1'b0;
    strap_ext = 1'b0;
    step();
    check("R4 strap ignored", drv_en, 8'h09);
    fetch(1'b1, 3'b111);
    step();
    check("R5 bhe drv", drv_en, 8'h29);
    check("R7 late pins weak", pull_en, 8'h96);
    check("R5 bhe value", {7'b0, pin_out[5]}, 8'h01);
    pin_in[6] = 1'b0;
    #1 check("R6 ready follows pin", {7'b0, ready_in}, 8'h00);
    pin_in[6] = 1'b1;
    check("R10 no conflict before write", {7'b0, cfg_conflict}, 8'h00);
    fetch(1'b0, 3'b000);
    step();
    check("R11 second fetch drv", drv_en, 8'h29);
    check("R11 second fetch pull", pull_en, 8'h96);
    mode_write(8'h00);
    check("R10 conflict raised", {7'b0, cfg_conflict}, 8'h01);
    pin_in[6] = 1'b0;
    #1 check("R6 ready high as io", {7'b0, ready_in}, 8'h01);
    pin_in[6] = 1'b1;
    for (int i = 0; i < 5; i++) begin
      port_oe = VEC[i][31:24]; port_dout = VEC[i][23:16];
      mode_write(VEC[i][39:32]);
      check("R9 pull released", pull_en, 8'h00);
      check("R9 drv pattern", drv_en, VEC[i][15:8]);
      check("R9 out pattern", pin_out, VEC[i][7:0]);
    end
    mode_write(8'h40);
    check("R10 conflict cleared", {7'b0, cfg_conflict}, 8'h00);

    // internal strap, pin 4 low during reset
    port_oe = 8'h00; port_dout = 8'h00;
    do_reset(1'b0, 1'b0);
    rst_n = 1'b1;
    pin_in[4] = 1'b1;
    step();
    check("R8 test req held", {7'b0, test_req}, 8'h01);
    check("R3 pull internal", pull_en, 8'hFF);
    check("R3 drv internal", drv_en, 8'h00);
    port_oe = 8'h40; port_dout = 8'h40;
    fetch(1'b0, 3'b101);
    step();
    check("R6 io pull", pull_en, 8'hBF);
    check("R6 io drv", drv_en, 8'h40);
    check("R6 io out", pin_out, 8'hFF);
    check("R6 ready idle", {7'b0, ready_in}, 8'h01);
    check("R5 narrow weak", {7'b0, pull_en[5]}, 8'h01);
    pin_in = 8'h5A;
    #1 check("R12 din", port_din, 8'h5A);
    check("R12 width idle", {7'b0, width_in}, 8'h00);
    check("R10 no conflict", {7'b0, cfg_conflict}, 8'h00);
    mode_write(8'h80);
    check("R3 released", pull_en, 8'h00);
    pin_in[7] = 1'b1;
    #1 check("R12 width follows", {7'b0, width_in}, 8'h01);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule